// File: doc/BRIEF.md
# Octal DAC Serial Write Controller

This block is the digital front end of an eight-channel voltage-output converter. It receives 16-bit frames on a three-wire serial link made of a serial clock, an active-low frame select and a data line. It resynchronises all three into one system clock and shifts data in on each falling edge of the serial clock, most significant bit first. A completed frame is either a channel code write or a control write. Channel codes land in one of eight input registers. Control writes set per-channel power-down flags or per-group reference options.

The codes reach the outputs through a second bank of eight DAC registers. An active-low load input controls the copy from the input bank into the DAC bank. While load is low, every input register is copied into its DAC register on each system clock. A short low pulse therefore updates all channels at once. Holding load low makes each finished write show at its output directly.

A frame counts only after exactly sixteen falling edges. If the frame select rises earlier, the partial frame is thrown away and no register changes.

Top module: `octdac_front`

## Requirements
- R1: While the frame select is low, one data bit is taken on each falling edge of the serial clock, first bit into bit 15. A frame with bit 15 = 0 is a code write: bits 14:12 pick the channel (0 = A up to 7 = H) and bits 11:0 carry the code, which goes into that channel's input register.
- R2: A frame takes effect after its sixteenth falling edge, and only once. Further falling edges are ignored until the frame select has gone high again.
- R3: If the frame select rises before the sixteenth falling edge, the frame is dropped: no code, flag or option changes.
- R4: While the load input is high, the DAC registers keep their values, even while code writes reach the input registers.
- R5: While the load input is low, every input register is copied into its DAC register, so a single low pulse updates all channels together.
- R6: With the load input held low, a completed code write appears on its channel's output without any further action.
- R7: Reset sets every input register and every DAC register to code zero, and clears all power-down flags and reference options.
- R8: A frame with bits 15:13 = 3'b101 loads the power-down flags from bits 7:0: bit i belongs to channel i, and 1 means powered down. Channel codes are left unchanged.
- R9: A frame with bits 15:13 = 3'b100 sets the reference options. Bit 0 is the buffered-reference select for channels A to D and bit 1 the same for E to H. Bit 2 is the supply-as-reference select for A to D and bit 3 the same for E to H.
- R10: A frame with bits 15:13 = 3'b110 or 3'b111 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; data is taken on its falling edge |
| ser_frame_n_i | input | 1 | Active-low frame select |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| load_n_i | input | 1 | Active-low transfer of input registers into DAC registers |
| dac_codes_o | output | 8*CODE_W | DAC register codes, channel i at bits i*CODE_W upward |
| pwr_down_o | output | 8 | Per-channel power-down flags, 1 = powered down |
| ref_buf_o | output | 2 | Buffered-reference select per group (bit 0 = A to D) |
| ref_vdd_o | output | 2 | Supply-as-reference select per group (bit 0 = A to D) |

## Verification
The hardest cases to reach from the ports are the frame edge cases. One is a partial frame that is abandoned one edge short of complete. Another is a frame that keeps clocking past sixteen edges, because from the outside both look like any other write. The stimulus task takes a bit count and a count of surplus edges, so frames of 10, 12, 15, 16 and 20 edges are sent to channels whose codes are known. A wrong count then shows up as a changed or shifted code. Hold and release of the DAC bank is tested by writing two channels while load is high, checking that both outputs stay at zero, and then checking that one pulse moves both.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    localparam int FRAME_W = 16;
    localparam int NUM_CH  = 8;
    localparam int ADDR_W  = $clog2(NUM_CH);
    localparam int GROUPS  = 2;

    // Control function selected by frame bits 14:13
    typedef enum logic [1:0] {
        CTL_REF  = 2'b00,
        CTL_PWR  = 2'b01,
        CTL_RSV2 = 2'b10,
        CTL_RSV3 = 2'b11
    } ctl_fn_e;

endpackage

// File: rtl/octdac_sync.sv
module octdac_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/octdac_rx.sv
module octdac_rx
    import octdac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               frame_n_s,
    input  logic               din_s,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_word
);

    localparam int               CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_W);

    typedef struct packed {
        logic               sclk_prev;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               vld;
    } rx_t;

    rx_t rx_q, rx_d;
    logic fall;

    always_comb begin
        rx_d           = rx_q;
        rx_d.vld       = 1'b0;
        rx_d.sclk_prev = sclk_s;
        fall           = rx_q.sclk_prev & ~sclk_s;
        if (frame_n_s) begin
            // idle or interrupted: any partial frame is forgotten
            rx_d.cnt = '0;
        end else if (fall && rx_q.cnt != FULL) begin
            rx_d.shreg = {rx_q.shreg[FRAME_W-2:0], din_s};
            rx_d.cnt   = rx_q.cnt + 1'b1;
            if (rx_q.cnt == LAST) begin
                rx_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{sclk_prev: 1'b1, default: '0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign frame_vld  = rx_q.vld;
    assign frame_word = rx_q.shreg;

endmodule

// File: rtl/octdac_bank.sv
module octdac_bank
    import octdac_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_vld,
    input  logic [FRAME_W-1:0]       frame_word,
    input  logic                     xfer_s,
    output logic [NUM_CH*CODE_W-1:0] dac_flat,
    output logic [NUM_CH-1:0]        pwr_down,
    output logic [GROUPS-1:0]        ref_buf,
    output logic [GROUPS-1:0]        ref_vdd
);

    localparam int CODE_MSB = FRAME_W - 1 - 1 - ADDR_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t [NUM_CH-1:0] in_reg;
        code_t [NUM_CH-1:0] dac_reg;
        logic  [NUM_CH-1:0] pd;
        logic  [GROUPS-1:0] rbuf;
        logic  [GROUPS-1:0] rvdd;
    } bank_t;

    bank_t bank_q, bank_d;

    logic              is_ctl;
    logic [ADDR_W-1:0] addr;
    code_t             code;
    ctl_fn_e           fn;
    logic              unused_word;

    assign is_ctl      = frame_word[FRAME_W-1];
    assign addr        = frame_word[FRAME_W-2 -: ADDR_W];
    assign code        = frame_word[CODE_MSB -: CODE_W];
    assign fn          = ctl_fn_e'(frame_word[FRAME_W-2 -: 2]);
    assign unused_word = ^frame_word;

    always_comb begin
        bank_d = bank_q;
        if (frame_vld) begin
            if (!is_ctl) begin
                bank_d.in_reg[addr] = code;
            end else begin
                case (fn)
                    CTL_REF: begin
                        bank_d.rbuf = frame_word[GROUPS-1:0];
                        bank_d.rvdd = frame_word[2*GROUPS-1:GROUPS];
                    end
                    CTL_PWR: bank_d.pd = frame_word[NUM_CH-1:0];
                    default: ;
                endcase
            end
        end
        if (xfer_s) begin
            for (int i = 0; i < NUM_CH; i++) begin
                bank_d.dac_reg[i] = bank_q.in_reg[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        assign dac_flat[g*CODE_W +: CODE_W] = bank_q.dac_reg[g];
    end

    assign pwr_down = bank_q.pd;
    assign ref_buf  = bank_q.rbuf;
    assign ref_vdd  = bank_q.rvdd;

endmodule

// File: rtl/octdac_front.sv
module octdac_front
    import octdac_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk_i,
    input  logic                     ser_frame_n_i,
    input  logic                     ser_data_i,
    input  logic                     load_n_i,
    output logic [NUM_CH*CODE_W-1:0] dac_codes_o,
    output logic [NUM_CH-1:0]        pwr_down_o,
    output logic [GROUPS-1:0]        ref_buf_o,
    output logic [GROUPS-1:0]        ref_vdd_o
);

    // pin order in the sync vector: {load_n, data, frame_n, sclk}
    localparam logic [3:0] PIN_IDLE = 4'b1011;

    logic [3:0]         pins_s;
    logic               sclk_s, frame_n_s, din_s, xfer_s;
    logic               frame_vld;
    logic [FRAME_W-1:0] frame_word;

    octdac_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({load_n_i, ser_data_i, ser_frame_n_i, ser_clk_i}),
        .sync_o  (pins_s)
    );

    assign sclk_s    = pins_s[0];
    assign frame_n_s = pins_s[1];
    assign din_s     = pins_s[2];
    assign xfer_s    = ~pins_s[3];

    octdac_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .frame_n_s  (frame_n_s),
        .din_s      (din_s),
        .frame_vld  (frame_vld),
        .frame_word (frame_word)
    );

    octdac_bank #(
        .CODE_W (CODE_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame_word (frame_word),
        .xfer_s     (xfer_s),
        .dac_flat   (dac_codes_o),
        .pwr_down   (pwr_down_o),
        .ref_buf    (ref_buf_o),
        .ref_vdd    (ref_vdd_o)
    );

endmodule

// File: rtl/octdac_front_chk.sv
module octdac_front_chk
    import octdac_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     frame_n_s,
    input logic                     frame_vld,
    input logic                     xfer_s,
    input logic [NUM_CH*CODE_W-1:0] dac_codes_o,
    input logic [NUM_CH-1:0]        pwr_down_o,
    input logic [GROUPS-1:0]        ref_buf_o,
    input logic [GROUPS-1:0]        ref_vdd_o
);

    // R3
    commit_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> !$past(frame_n_s));

    // R2
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);

    // R4
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_s |=> $stable(dac_codes_o));

    // R8
    pd_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(pwr_down_o));

    // R9
    ref_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable({ref_buf_o, ref_vdd_o}));

endmodule

bind octdac_front octdac_front_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n_s   (frame_n_s),
    .frame_vld   (frame_vld),
    .xfer_s      (xfer_s),
    .dac_codes_o (dac_codes_o),
    .pwr_down_o  (pwr_down_o),
    .ref_buf_o   (ref_buf_o),
    .ref_vdd_o   (ref_vdd_o)
);

// File: tb/octdac_front_bench.sv
`timescale 1ns/1ps
module octdac_front_bench;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b1;
    logic          frame_n = 1'b1;
    logic          din = 1'b0;
    logic          load_n = 1'b1;
    logic [8*CW-1:0] codes;
    logic [7:0]    pd;
    logic [1:0]    rbuf, rvdd;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    octdac_front u_octdac_front (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_clk_i     (sclk),
        .ser_frame_n_i (frame_n),
        .ser_data_i    (din),
        .load_n_i      (load_n),
        .dac_codes_o   (codes),
        .pwr_down_o    (pd),
        .ref_buf_o     (rbuf),
        .ref_vdd_o     (rvdd)
    );

    typedef struct packed {
        logic [15:0] word;
        logic [4:0]  nbits;
        logic [2:0]  ch;
        logic [11:0] exp;
    } vec_t;

    // load held low; short frames must leave the channel untouched (R3)
    localparam vec_t VECS [8] = '{
        '{16'h0ABC, 5'd16, 3'd0, 12'hABC},
        '{16'h7123, 5'd16, 3'd7, 12'h123},
        '{16'h3FFF, 5'd16, 3'd3, 12'hFFF},
        '{16'h1555, 5'd10, 3'd1, 12'h000},
        '{16'h1AAA, 5'd16, 3'd1, 12'hAAA},
        '{16'h5800, 5'd15, 3'd5, 12'h000},
        '{16'h5800, 5'd16, 3'd5, 12'h800},
        '{16'h0001, 5'd16, 3'd0, 12'h001}
    };

    function automatic logic [CW-1:0] chan(input int c);
        return codes[c*CW +: CW];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input int extra);
        @(negedge clk);
        frame_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits + extra; i++) begin
            din = (i < nbits) ? w[15-i] : 1'b1;
            wait_clk(3);
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(3);
        end
        frame_n = 1'b1;
        din = 1'b0;
        wait_clk(10);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R7 reset state
        check("R7 codes", 32'(codes == '0), 32'd1);
        check("R7 pd", 32'(pd), 32'h0);
        check("R7 ref", 32'({rbuf, rvdd}), 32'h0);

        // R4 hold while load high
        send(16'h2456, 16, 0);
        send(16'h4777, 16, 0);
        check("R4 ch2 held", 32'(chan(2)), 32'h0);
        check("R4 ch4 held", 32'(chan(4)), 32'h0);

        // R5 one pulse moves both
        load_n = 1'b0;
        wait_clk(6);
        load_n = 1'b1;
        wait_clk(6);
        check("R5 ch2", 32'(chan(2)), 32'h456);
        check("R5 ch4", 32'(chan(4)), 32'h777);

        // R1 R3 R6 table with load held low
        load_n = 1'b0;
        wait_clk(4);
        for (int k = 0; k < 8; k++) begin
            send(VECS[k].word, int'(VECS[k].nbits), 0);
            check($sformatf("R6/R1/R3 vec%0d", k), 32'(chan(int'(VECS[k].ch))), 32'(VECS[k].exp));
        end
        check("R1 ch2 untouched", 32'(chan(2)), 32'h456);

        // R2 surplus edges ignored
        send(16'h2321, 16, 4);
        check("R2 surplus edges", 32'(chan(2)), 32'h321);

        // R8 power-down
        send(16'hA05A, 16, 0);
        check("R8 pd", 32'(pd), 32'h5A);
        check("R8 codes kept", 32'(chan(0)), 32'h001);

        // R9 reference options
        send(16'h8009, 16, 0);
        check("R9 buf", 32'(rbuf), 32'h1);
        check("R9 vdd", 32'(rvdd), 32'h2);

        // R10 reserved functions
        send(16'hC0FF, 16, 0);
        send(16'hE0FF, 16, 0);
        check("R10 pd", 32'(pd), 32'h5A);
        check("R10 ref", 32'({rbuf, rvdd}), 32'h6);
        check("R10 codes", 32'(chan(7)), 32'h123);

        // R3 interrupted control frame
        send(16'hA0FF, 12, 0);
        check("R3 pd kept", 32'(pd), 32'h5A);

        // R7 reset again
        rst_n = 1'b0;
        wait_clk(3);
        check("R7 codes again", 32'(codes == '0), 32'd1);
        check("R7 pd again", 32'(pd), 32'h0);
        rst_n = 1'b1;
        wait_clk(2);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule